// File: doc/BRIEF.md
# Bus Error Monitor with Tenure Watchdogs

This block observes a pipelined system bus from the side and turns protocol trouble into interrupts. It runs one watchdog for the open address phase and one for the open data phase. When either phase stays open longer than its programmed number of cycles, the block records a timeout. It decodes the transfer code of every address phase, and in the same cycle it answers for transfers that no target may take (address-only, reserved and illegal codes), so that such a phase does not hang the bus. It also records transfer errors signalled by targets.

There are four error sources. Each one has a sticky status bit, an enable bit and a routing bit. The routing bit sends the source either to the ordinary interrupt line or to the machine-check line. The first error after the status has been fully cleared also records the master number and the transfer code in a capture register. Software reaches all of this through a single-cycle register port. Writes take effect at the clock edge, and reads are combinational.

Top module: `bmon_top`

## Requirements
- R1: `claim` is high in exactly those cycles where `a_start` is high and `a_type` is 4 to 7 (bit 2 set). Such a start opens no address watchdog, and status bit 0 is set at the next edge. Codes 0 to 3 are never claimed.
- R2: After an unclaimed `a_start` at edge E0 with no `a_ack` in the same cycle, if `a_ack` is absent at every edge E1..EL (L being the address limit), status bit 1 is set at EL and the address phase is closed. An `a_ack` at or before EL prevents the timeout.
- R3: The data watchdog behaves the same way: it opens on `d_start`, closes on `d_last`, uses the data limit and sets status bit 2.
- R4: A limit value of zero disables that watchdog, so no timeout occurs however long the phase stays open.
- R5: `xfer_err` high at an edge sets status bit 3.
- R6: Status bits are sticky. A write to address 0 clears each bit whose write-data bit is 1. A new event in the same cycle wins over the clear.
- R7: An event at an edge where all status bits were zero loads the capture register (address 5: bits 3:0 master, bits 6:4 transfer code) from the lowest-numbered source that fired. The claim source and the address timeout use the address-phase master and code. The data timeout and the transfer error use `d_mid` with code 0. At all other times the capture register holds its value.
- R8: `irq_mchk` is the OR over the sources of status AND enable AND route. `irq_norm` is the OR over the sources of status AND enable AND NOT route.
- R9: Register map: 0 status, 1 enable, 2 route (bit i selects machine check for source i), 3 address limit, 4 data limit, 5 capture. Other addresses read zero. After reset every register reads zero.
- R10: A start and an end in the same cycle open no phase. A new start while a phase is open restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_start | input | 1 | Address phase begins this cycle |
| a_ack | input | 1 | Address acknowledge |
| a_mid | input | 4 | Master number of the address phase |
| a_type | input | 3 | Transfer code of the address phase |
| d_start | input | 1 | Data phase begins this cycle |
| d_last | input | 1 | Last data beat |
| d_mid | input | 4 | Master number of the current data beat |
| xfer_err | input | 1 | Transfer error reported by a target |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| claim | output | 1 | Monitor answers this address phase |
| irq_norm | output | 1 | Ordinary interrupt |
| irq_mchk | output | 1 | Machine-check interrupt |

## Verification
Some properties are checked on every cycle. Status bits must survive any cycle without a status write. A claimed start must not open the address watchdog. An expired or finished phase must close. With nothing enabled, both interrupt lines must stay low. The exact timeout edge, the races of acknowledge against limit and of clear against set, the capture priority, and the routing of each source can only be shown by the bench. It compares the claim line, both interrupt lines and a rotating register read against its reference model on every clock.

// File: rtl/bmon_pkg.sv
package bmon_pkg;
    localparam int MID_W  = 4;
    localparam int TYP_W  = 3;
    localparam int NSRC   = 4;
    localparam int SEL_W  = $clog2(NSRC);
    localparam int RA_W   = 3;

    // source numbering doubles as capture priority (lowest wins)
    localparam int S_CLAIM = 0;
    localparam int S_ATMO  = 1;
    localparam int S_DTMO  = 2;
    localparam int S_XERR  = 3;

    localparam logic [RA_W-1:0] RA_STAT  = 3'd0;
    localparam logic [RA_W-1:0] RA_EN    = 3'd1;
    localparam logic [RA_W-1:0] RA_ROUTE = 3'd2;
    localparam logic [RA_W-1:0] RA_ALIM  = 3'd3;
    localparam logic [RA_W-1:0] RA_DLIM  = 3'd4;
    localparam logic [RA_W-1:0] RA_CAP   = 3'd5;

    typedef struct packed {
        logic [TYP_W-1:0] typ;
        logic [MID_W-1:0] mid;
    } tag_t;

    // codes with the top bit set have no legal target
    function automatic logic is_claimed(input logic [TYP_W-1:0] t);
        return t[TYP_W-1];
    endfunction
endpackage

// File: rtl/bmon_tenure_timer.sv
module bmon_tenure_timer
    import bmon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             done,
    input  logic [CNT_W-1:0] limit,
    input  tag_t             tag_in,
    output logic             open_o,
    output logic             expire_o,
    output tag_t             tag_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // fires on the edge that would complete the limit-th waiting cycle
    always_comb
        expire_o = open_o && !done && (limit != '0) && ((cnt + ONE) == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_o <= 1'b0;
            cnt    <= '0;
            tag_o  <= '0;
        end else if (start && !done) begin
            // R10: a fresh start (re)arms the count
            open_o <= 1'b1;
            cnt    <= '0;
            tag_o  <= tag_in;
        end else if (open_o) begin
            if (done || expire_o)
                open_o <= 1'b0;
            else if (limit != '0)
                cnt <= cnt + ONE;
        end
    end

    p_expire_closes_r2: assert property (@(posedge clk) disable iff (rst)
        (expire_o && !start) |=> !open_o);

    p_done_closes_r3: assert property (@(posedge clk) disable iff (rst)
        (open_o && done && !start) |=> !open_o);
endmodule

// File: rtl/bmon_err_regs.sv
module bmon_err_regs
    import bmon_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [RA_W-1:0]  addr,
    input  logic [DW-1:0]    wdata,
    input  logic [NSRC-1:0]  ev,
    input  tag_t             ev_tag [NSRC],
    output logic [NSRC-1:0]  status,
    output logic [NSRC-1:0]  enable,
    output logic [NSRC-1:0]  route,
    output logic [CNT_W-1:0] alim,
    output logic [CNT_W-1:0] dlim,
    output logic [DW-1:0]    rdata
);
    tag_t            cap;
    logic [SEL_W-1:0] first;
    logic [NSRC-1:0] clr;
    logic            unused_wdata;

    assign unused_wdata = ^wdata;

    // R7: lowest-numbered firing source wins the capture
    always_comb begin
        first = '0;
        for (int i = NSRC - 1; i >= 0; i--)
            if (ev[i]) first = SEL_W'(i);
    end

    always_comb clr = (we && addr == RA_STAT) ? wdata[NSRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
            route  <= '0;
            alim   <= '0;
            dlim   <= '0;
            cap    <= '0;
        end else begin
            // R6: set dominates the write-one clear
            status <= (status & ~clr) | ev;
            if (status == '0 && ev != '0)
                cap <= ev_tag[first];
            if (we) begin
                case (addr)
                    RA_EN:    enable <= wdata[NSRC-1:0];
                    RA_ROUTE: route  <= wdata[NSRC-1:0];
                    RA_ALIM:  alim   <= wdata[CNT_W-1:0];
                    RA_DLIM:  dlim   <= wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // R9: read map
    always_comb begin
        rdata = '0;
        case (addr)
            RA_STAT:  rdata[NSRC-1:0]  = status;
            RA_EN:    rdata[NSRC-1:0]  = enable;
            RA_ROUTE: rdata[NSRC-1:0]  = route;
            RA_ALIM:  rdata[CNT_W-1:0] = alim;
            RA_DLIM:  rdata[CNT_W-1:0] = dlim;
            RA_CAP: begin
                rdata[MID_W-1:0]       = cap.mid;
                rdata[MID_W +: TYP_W]  = cap.typ;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bmon_top.sv
module bmon_top
    import bmon_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_start,
    input  logic              a_ack,
    input  logic [MID_W-1:0]  a_mid,
    input  logic [TYP_W-1:0]  a_type,
    input  logic              d_start,
    input  logic              d_last,
    input  logic [MID_W-1:0]  d_mid,
    input  logic              xfer_err,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              claim,
    output logic              irq_norm,
    output logic              irq_mchk
);
    logic [NSRC-1:0]  ev, status, enable, route;
    logic [CNT_W-1:0] alim, dlim;
    tag_t             ev_tag [NSRC];
    tag_t             a_tag, d_tag, a_held, d_held;
    logic             a_open, a_exp, d_open, d_exp;

    // R1: answer forbidden codes in the same cycle
    assign claim = a_start && is_claimed(a_type);

    assign a_tag = '{typ: a_type, mid: a_mid};
    assign d_tag = '{typ: '0,     mid: d_mid};

    bmon_tenure_timer #(.CNT_W(CNT_W)) u_atmr (
        .clk(clk), .rst(rst),
        .start(a_start && !claim), .done(a_ack),
        .limit(alim), .tag_in(a_tag),
        .open_o(a_open), .expire_o(a_exp), .tag_o(a_held)
    );

    bmon_tenure_timer #(.CNT_W(CNT_W)) u_dtmr (
        .clk(clk), .rst(rst),
        .start(d_start), .done(d_last),
        .limit(dlim), .tag_in(d_tag),
        .open_o(d_open), .expire_o(d_exp), .tag_o(d_held)
    );

    always_comb begin
        ev             = '0;
        ev[S_CLAIM]    = claim;
        ev[S_ATMO]     = a_exp;
        ev[S_DTMO]     = d_exp;
        ev[S_XERR]     = xfer_err;
        ev_tag[S_CLAIM] = a_tag;
        ev_tag[S_ATMO]  = a_held;
        ev_tag[S_DTMO]  = d_held;
        ev_tag[S_XERR]  = d_tag;
    end

    bmon_err_regs #(.CNT_W(CNT_W), .DW(DW)) u_regs (
        .clk(clk), .rst(rst),
        .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .ev(ev), .ev_tag(ev_tag),
        .status(status), .enable(enable), .route(route),
        .alim(alim), .dlim(dlim), .rdata(reg_rdata)
    );

    // R8: per-source steering
    assign irq_mchk = |(status & enable & route);
    assign irq_norm = |(status & enable & ~route);

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == RA_STAT) |=> ((status & $past(status)) == $past(status)));

    p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |-> (!irq_norm && !irq_mchk));

    p_claim_no_timer_r1: assert property (@(posedge clk) disable iff (rst)
        (claim && !a_open) |=> !a_open);
endmodule

// File: tb/sim_bmon_top.sv
module sim_bmon_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_start = 0, a_ack = 0, d_start = 0, d_last = 0, xfer_err = 0;
    logic [3:0]  a_mid = 0, d_mid = 0;
    logic [2:0]  a_type = 0;
    logic        reg_we = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        claim, irq_norm, irq_mchk;

    int vectors = 0, errors = 0, rot = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bmon_top u0 (
        .clk(clk), .rst(rst), .a_start(a_start), .a_ack(a_ack), .a_mid(a_mid),
        .a_type(a_type), .d_start(d_start), .d_last(d_last), .d_mid(d_mid),
        .xfer_err(xfer_err), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .claim(claim),
        .irq_norm(irq_norm), .irq_mchk(irq_mchk)
    );

    // ---------------- reference model ----------------
    int m_st, m_en, m_rt, m_al, m_dl, m_cap;
    bit ab, db;
    int ac, dc, a_tg, d_tg;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_en = 0; m_rt = 0; m_al = 0; m_dl = 0; m_cap = 0;
            ab = 0; db = 0; ac = 0; dc = 0; a_tg = 0; d_tg = 0;
        end else begin
            int ev;
            int tg [4];
            bit ato, dto;
            ev = 0;
            tg[0] = a_type * 16 + a_mid;
            tg[1] = a_tg;
            tg[2] = d_tg;
            tg[3] = d_mid;
            if (a_start && a_type >= 4) ev |= 1;
            ato = ab && !a_ack && m_al != 0 && ac + 1 == m_al;
            dto = db && !d_last && m_dl != 0 && dc + 1 == m_dl;
            if (ato) ev |= 2;
            if (dto) ev |= 4;
            if (xfer_err) ev |= 8;
            if (m_st == 0 && ev != 0) begin
                for (int i = 3; i >= 0; i--) if (ev[i]) m_cap = tg[i];
            end
            if (a_start && a_type < 4 && !a_ack) begin
                ab = 1; ac = 0; a_tg = a_type * 16 + a_mid;
            end else if (ab) begin
                if (a_ack || ato) ab = 0;
                else if (m_al != 0) ac++;
            end
            if (d_start && !d_last) begin
                db = 1; dc = 0; d_tg = d_mid;
            end else if (db) begin
                if (d_last || dto) db = 0;
                else if (m_dl != 0) dc++;
            end
            if (reg_we && reg_addr == 0) m_st = m_st & ~(reg_wdata & 15);
            m_st |= ev;
            if (reg_we) begin
                case (reg_addr)
                    1: m_en = reg_wdata & 15;
                    2: m_rt = reg_wdata & 15;
                    3: m_al = reg_wdata & 16'hffff;
                    4: m_dl = reg_wdata & 16'hffff;
                    default: ;
                endcase
            end
        end
    end

    function automatic int exp_rd(input int a);
        case (a)
            0: return m_st;
            1: return m_en;
            2: return m_rt;
            3: return m_al;
            4: return m_dl;
            5: return m_cap;
            default: return 0;
        endcase
    endfunction

    function automatic string rd_tag(input int a);
        case (a)
            0: return "R2/R3/R5/R6 status";
            5: return "R7 capture";
            default: return "R9 register";
        endcase
    endfunction

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit ec, en, em;
            int er;
            ec = a_start && a_type >= 4;
            en = ((m_st & m_en & ~m_rt) & 15) != 0;
            em = (m_st & m_en & m_rt) != 0;
            er = exp_rd(reg_addr);
            vectors++;
            if (claim !== ec) begin
                errors++;
                $display("FAIL R1 claim: got %0b expected %0b", claim, ec);
            end
            if (irq_norm !== en) begin
                errors++;
                $display("FAIL R8 irq_norm: got %0b expected %0b", irq_norm, en);
            end
            if (irq_mchk !== em) begin
                errors++;
                $display("FAIL R8 irq_mchk: got %0b expected %0b", irq_mchk, em);
            end
            if (reg_rdata !== 32'(er)) begin
                errors++;
                $display("FAIL %s addr %0d: got %h expected %h",
                         rd_tag(reg_addr), reg_addr, reg_rdata, er);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk);
        #1;
        a_start = 0; a_ack = 0; d_start = 0; d_last = 0; xfer_err = 0;
        reg_we = 0; reg_wdata = 0;
        reg_addr = 3'(rot);
        rot++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input int a, input int d);
        reg_we = 1; reg_addr = 3'(a); reg_wdata = d;
        tick();
    endtask

    task automatic astart(input int t, input int m, input bit ack);
        a_start = 1; a_type = 3'(t); a_mid = 4'(m); a_ack = ack;
        tick();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        idle(10);                       // R9 reset values read back
        wr(1, 15); wr(2, 0); wr(3, 5); wr(4, 4);
        idle(8);
        // R1: every code, normal codes acknowledged at once
        for (int t = 0; t < 8; t++) begin
            astart(t, t + 2, t < 4);
            idle(2);
            wr(0, 15);
        end
        // R2: timeout exactly at the limit, and ack on the last edge
        astart(1, 9, 0); idle(8); wr(0, 15); idle(2);
        astart(2, 6, 0); idle(4); a_ack = 1; tick(); idle(4);
        // R3: data watchdog, last beat on the boundary and too late
        d_start = 1; d_mid = 4'd7; tick(); idle(6); wr(0, 15);
        d_start = 1; d_mid = 4'd3; tick(); idle(3); d_last = 1; tick(); idle(4);
        // R4: limit zero disables both
        wr(3, 0); wr(4, 0);
        astart(0, 1, 0); d_start = 1; tick(); idle(30);
        a_ack = 1; d_last = 1; tick();
        wr(3, 1); wr(4, 2); idle(3);
        // limit 1: expires on the first edge
        astart(0, 5, 0); idle(3); wr(0, 15);
        // R5 and R8: routing and masking
        wr(2, 4'b1010);
        d_mid = 4'd12; xfer_err = 1; tick(); idle(3);
        astart(6, 11, 0); idle(3);
        wr(1, 4'b0001); idle(3);
        wr(1, 0); idle(3);
        wr(1, 15);
        wr(0, 8); idle(2);
        wr(0, 15); idle(2);
        // R6: set and clear in the same cycle
        xfer_err = 1; tick();
        xfer_err = 1; reg_we = 1; reg_addr = 0; reg_wdata = 8; tick(); idle(3);
        wr(0, 15); idle(2);
        // R7: simultaneous sources, lowest wins; later ones do not recapture
        d_mid = 4'd2; xfer_err = 1; a_start = 1; a_type = 3'd7; a_mid = 4'd13; tick();
        idle(3);
        xfer_err = 1; d_mid = 4'd9; tick(); idle(6);
        wr(0, 1); idle(2); xfer_err = 1; d_mid = 4'd4; tick(); idle(6);
        wr(0, 15); idle(2);
        // R10: start with end in the same cycle; restart while open
        wr(3, 5);
        astart(0, 2, 1); idle(8);
        d_start = 1; d_last = 1; d_mid = 4'd1; tick(); idle(8);
        astart(3, 8, 0); idle(3); astart(1, 10, 0); idle(3);
        a_ack = 1; tick(); idle(4);
        astart(3, 8, 0); idle(3); astart(1, 10, 0); idle(7);
        wr(0, 15); idle(8);
        finish_run();
    end
endmodule